// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns a 6-bit operand code into an operand for a 16-bit, word-addressed processor. It owns the eight general registers, the stack pointer, the program counter and the overflow register. For each accepted request it works out where the operand lives and what it holds. The operand can be a register, an inline constant, a special register, or a memory word reached through a register, through an extension word, or through the stack pointer. When the code calls for an extension word, the block reads it from memory at the program counter and advances the counter. The stack modes move the stack pointer. Memory is a synchronous word store reached through a one-cycle request strobe, and the data comes back later under its own valid strobe.

A request is offered with `req_valid` and taken only while `req_ready` is high, which is only in the idle state. A request held while `req_ready` is low simply waits. The result is not back-pressured. `done` is high for exactly one cycle, and in that cycle `res_value`, `res_addr`, `res_has_addr` and `res_literal` are valid. They then hold until the next result. In skip mode the block resolves nothing. It only steps the program counter past any extension word the code would have consumed. An execution stage loads registers through a write port that acts only while the block is idle, and it reads them through a combinational read port.

Top module: `opnd_resolver`

## Requirements
- R1: Codes 0x00..0x07 return general register `code[2:0]` (selector order A,B,C,X,Y,Z,I,J = 0..7) with no memory access. `res_has_addr` is 0 and `done` rises 2 edges after the accepting edge.
- R2: Codes 0x08..0x0F read memory at general register `code[2:0]`. The result reports that address with `res_has_addr`=1 and the value read, and `done` rises 3 edges after acceptance when memory answers one cycle after a request.
- R3: Codes 0x10..0x17 fetch an extension word at PC and increment PC. They then read memory at (extension word + register `code[2:0]`) modulo 2^16, and `done` rises 4 edges after acceptance.
- R4: Code 0x18 uses memory at SP and then increments SP. Code 0x19 uses memory at SP and leaves SP unchanged. Code 0x1A decrements SP first and uses memory at the new SP. All SP arithmetic wraps modulo 2^16.
- R5: Codes 0x1B, 0x1C and 0x1D return the current SP, PC and overflow register respectively, with no memory access.
- R6: Code 0x1E fetches an extension word, increments PC and reads memory at that word (4 edges). Code 0x1F fetches an extension word, increments PC and returns the word itself (3 edges, `res_has_addr`=0).
- R7: Codes 0x20..0x3F return `code & 0x1F` with no memory access (2 edges).
- R8: `res_literal` is 1 exactly when the resolved code is 0x1F or above, which marks that a write to this operand must be dropped.
- R9: `ext_count` increases by one for each extension-word fetch and for nothing else.
- R10: With `req_skip`=1, PC increases by one only for codes 0x10..0x17, 0x1E and 0x1F. SP, `ext_count` and all registers stay unchanged, no memory request is made, all result fields are 0, and `done` rises 2 edges after acceptance.
- R11: `done` is high for exactly one cycle per accepted request, and `req_ready` is high only while idle.
- R12: Write-port selector encoding: 0..7 select the general registers, 8 selects SP, 9 selects PC and 10 selects the overflow register. `rd_sel` uses the same encoding. A write is applied only in a cycle with `req_ready`=1 and is ignored otherwise. A write in the same cycle as an accepted request is visible to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Resolve request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_code | input | 6 | Operand code |
| req_skip | input | 1 | Skip mode: consume extension words only |
| done | output | 1 | One-cycle result strobe |
| res_value | output | 16 | Resolved operand value |
| res_addr | output | 16 | Effective memory address |
| res_has_addr | output | 1 | Operand lives in memory at res_addr |
| res_literal | output | 1 | Operand is a literal; writes to it must be dropped |
| mem_req | output | 1 | Memory read request strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Memory read data |
| wr_en | input | 1 | Register write enable (honoured when idle) |
| wr_sel | input | 4 | Register write selector |
| wr_data | input | 16 | Register write data |
| rd_sel | input | 4 | Register read selector |
| rd_data | output | 16 | Register read data (combinational) |
| ext_count | output | 32 | Extension-word fetch count |

## Verification
A register write and a request acceptance can fall in the same cycle. The bench provokes this by driving `wr_en` and `req_valid` together for a register code whose register is being written, and it requires the resolved value to equal the newly written data. The bench also drives a write while a 4-edge indexed resolution is in flight, and it requires the target register, read back through `rd_data` afterwards, to keep its old value.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int NGPR = 8;
  localparam int SELW = 4;
  localparam logic [SELW-1:0] SEL_SP = 4'd8;
  localparam logic [SELW-1:0] SEL_PC = 4'd9;
  localparam logic [SELW-1:0] SEL_OV = 4'd10;

  typedef enum logic [3:0] {
    K_REG, K_IND, K_IDX, K_POP, K_PEEK, K_PUSH,
    K_SP, K_PC, K_OV, K_NWADDR, K_NWLIT, K_SHORT
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_WEXT, ST_WDATA, ST_DONE
  } state_e;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [5:0] code,
  output kind_e      kind,
  output logic       needs_ext,
  output logic       is_lit
);
  always_comb begin
    if (code < 6'h08)      kind = K_REG;
    else if (code < 6'h10) kind = K_IND;
    else if (code < 6'h18) kind = K_IDX;
    else begin
      unique case (code)
        6'h18:   kind = K_POP;
        6'h19:   kind = K_PEEK;
        6'h1A:   kind = K_PUSH;
        6'h1B:   kind = K_SP;
        6'h1C:   kind = K_PC;
        6'h1D:   kind = K_OV;
        6'h1E:   kind = K_NWADDR;
        6'h1F:   kind = K_NWLIT;
        default: kind = K_SHORT;
      endcase
    end
  end

  assign needs_ext = (kind == K_IDX) || (kind == K_NWADDR) || (kind == K_NWLIT);
  assign is_lit    = (code >= 6'h1F);
endmodule

// File: rtl/opr_regbank.sv
module opr_regbank
  import opr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SELW-1:0]   wr_sel,
  input  logic [W-1:0]      wr_data,
  input  logic [$clog2(NGPR)-1:0] gidx,
  output logic [W-1:0]      gval,
  input  logic              sp_inc,
  input  logic              sp_dec,
  input  logic              pc_inc,
  output logic [W-1:0]      sp,
  output logic [W-1:0]      pc,
  output logic [W-1:0]      ov,
  input  logic [SELW-1:0]   rd_sel,
  output logic [W-1:0]      rd_data
);
  logic [W-1:0] gpr [NGPR];

  for (genvar g = 0; g < NGPR; g++) begin : g_gpr
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                q <= '0;
      else if (wr_en && wr_sel == SELW'(g))      q <= wr_data;
    end
    assign gpr[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      pc <= '0;
      ov <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_SP) sp <= wr_data;
      else if (sp_inc)               sp <= sp + W'(1);
      else if (sp_dec)               sp <= sp - W'(1);

      if (wr_en && wr_sel == SEL_PC) pc <= wr_data;
      else if (pc_inc)               pc <= pc + W'(1);

      if (wr_en && wr_sel == SEL_OV) ov <= wr_data;
    end
  end

  assign gval = gpr[gidx];

  always_comb begin
    if (rd_sel < SELW'(NGPR)) rd_data = gpr[rd_sel[$clog2(NGPR)-1:0]];
    else if (rd_sel == SEL_SP) rd_data = sp;
    else if (rd_sel == SEL_PC) rd_data = pc;
    else if (rd_sel == SEL_OV) rd_data = ov;
    else rd_data = '0;
  end
endmodule

// File: rtl/opr_cnt.sv
module opr_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opr_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [5:0]       req_code,
  input  logic             req_skip,
  output logic             done,
  output logic [W-1:0]     res_value,
  output logic [W-1:0]     res_addr,
  output logic             res_has_addr,
  output logic             res_literal,
  output logic             mem_req,
  output logic [W-1:0]     mem_addr,
  input  logic             mem_rvalid,
  input  logic [W-1:0]     mem_rdata,
  input  logic             wr_en,
  input  logic [SELW-1:0]  wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic [SELW-1:0]  rd_sel,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] ext_count
);
  localparam int GIW = $clog2(NGPR);

  state_e       state;
  logic [5:0]   code_q;
  logic         skip_q;
  kind_e        kind;
  logic         needs_ext, is_lit;
  logic [W-1:0] gval, sp, pc, ov;
  logic         sp_inc, sp_dec, pc_inc, cnt_inc;

  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);

  opr_decode u_dec (
    .code(code_q), .kind(kind), .needs_ext(needs_ext), .is_lit(is_lit)
  );

  opr_regbank #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && req_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .gidx(code_q[GIW-1:0]), .gval(gval),
    .sp_inc(sp_inc), .sp_dec(sp_dec), .pc_inc(pc_inc),
    .sp(sp), .pc(pc), .ov(ov),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  opr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .count(ext_count)
  );

  // Memory request and pointer side effects, issued from the current state.
  always_comb begin
    mem_req  = 1'b0;
    mem_addr = '0;
    sp_inc   = 1'b0;
    sp_dec   = 1'b0;
    pc_inc   = 1'b0;
    cnt_inc  = 1'b0;
    if (state == ST_EXEC) begin
      if (skip_q) begin
        pc_inc = needs_ext;
      end else begin
        unique case (kind)
          K_IND: begin mem_req = 1'b1; mem_addr = gval; end
          K_IDX, K_NWADDR, K_NWLIT: begin
            mem_req = 1'b1; mem_addr = pc; pc_inc = 1'b1; cnt_inc = 1'b1;
          end
          K_POP:  begin mem_req = 1'b1; mem_addr = sp; sp_inc = 1'b1; end
          K_PEEK: begin mem_req = 1'b1; mem_addr = sp; end
          K_PUSH: begin mem_req = 1'b1; mem_addr = sp - W'(1); sp_dec = 1'b1; end
          default: ;
        endcase
      end
    end else if (state == ST_WEXT && mem_rvalid && kind != K_NWLIT) begin
      mem_req  = 1'b1;
      mem_addr = (kind == K_IDX) ? mem_rdata + gval : mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      code_q       <= '0;
      skip_q       <= 1'b0;
      res_value    <= '0;
      res_addr     <= '0;
      res_has_addr <= 1'b0;
      res_literal  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          code_q <= req_code;
          skip_q <= req_skip;
          state  <= ST_EXEC;
        end
        ST_EXEC: begin
          res_literal <= skip_q ? 1'b0 : is_lit;
          if (skip_q) begin
            res_value    <= '0;
            res_addr     <= '0;
            res_has_addr <= 1'b0;
            state        <= ST_DONE;
          end else begin
            unique case (kind)
              K_REG, K_SP, K_PC, K_OV, K_SHORT: begin
                res_addr     <= '0;
                res_has_addr <= 1'b0;
                state        <= ST_DONE;
                unique case (kind)
                  K_REG:   res_value <= gval;
                  K_SP:    res_value <= sp;
                  K_PC:    res_value <= pc;
                  K_OV:    res_value <= ov;
                  default: res_value <= {{(W-5){1'b0}}, code_q[4:0]};
                endcase
              end
              K_IDX, K_NWADDR, K_NWLIT: state <= ST_WEXT;
              default: begin
                res_addr     <= mem_addr;
                res_has_addr <= 1'b1;
                state        <= ST_WDATA;
              end
            endcase
          end
        end
        ST_WEXT: if (mem_rvalid) begin
          if (kind == K_NWLIT) begin
            res_value    <= mem_rdata;
            res_addr     <= '0;
            res_has_addr <= 1'b0;
            state        <= ST_DONE;
          end else begin
            res_addr     <= mem_addr;
            res_has_addr <= 1'b1;
            state        <= ST_WDATA;
          end
        end
        ST_WDATA: if (mem_rvalid) begin
          res_value <= mem_rdata;
          state     <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opr_checker.sv
module opr_checker #(
  parameter int W     = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [5:0]       req_code,
  input logic             req_skip,
  input logic             done,
  input logic [W-1:0]     res_value,
  input logic             res_literal,
  input logic             mem_req,
  input logic [CNT_W-1:0] ext_count
);
  logic [5:0] code_l;
  logic       skip_l;
  logic       busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_l <= '0; skip_l <= 1'b0; busy <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        code_l <= req_code; skip_l <= req_skip; busy <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_literal_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !skip_l) |-> (res_literal == (code_l >= 6'h1F)));

  assert_short_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !skip_l && code_l >= 6'h20) |-> (res_value == {{(W-5){1'b0}}, code_l[4:0]}));

  assert_skip_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && skip_l) |-> !mem_req);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ext_count == $past(ext_count)) || (ext_count == $past(ext_count) + CNT_W'(1)));
endmodule

bind opnd_resolver opr_checker #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_code(req_code), .req_skip(req_skip), .done(done),
  .res_value(res_value), .res_literal(res_literal), .mem_req(mem_req),
  .ext_count(ext_count)
);

// File: tb/sim_opnd_resolver.sv
`timescale 1ns/1ps
module sim_opnd_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_skip = 1'b0;
  logic [5:0]  req_code = '0;
  logic        req_ready, done, res_has_addr, res_literal, mem_req;
  logic [15:0] res_value, res_addr, mem_addr, rd_data;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0, rd_sel = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] ext_count;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  opnd_resolver u0 (.*);

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  // synchronous word memory, answers one cycle after a request
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= memf(mem_addr);
  end

  // reference state
  logic [15:0] m_gpr [8];
  logic [15:0] m_sp = 0, m_pc = 0, m_ov = 0;
  logic [31:0] m_cnt = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] sel, output logic [15:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic check_state(input string req);
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin rd(4'(i), v); chk(req, "gpr", {16'h0, v}, {16'h0, m_gpr[i]}); end
    rd(4'd8, v);  chk(req, "sp", {16'h0, v}, {16'h0, m_sp});
    rd(4'd9, v);  chk(req, "pc", {16'h0, v}, {16'h0, m_pc});
    rd(4'd10, v); chk(req, "ov", {16'h0, v}, {16'h0, m_ov});
    chk(req == "R10" ? "R10" : "R9", "ext_count", ext_count, m_cnt);
  endtask

  task automatic mwrite(input logic [3:0] sel, input logic [15:0] d);
    if (sel < 8) m_gpr[sel] = d;
    else if (sel == 8) m_sp = d;
    else if (sel == 9) m_pc = d;
    else if (sel == 10) m_ov = d;
  endtask

  task automatic setreg(input logic [3:0] sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    mwrite(sel, d);
  endtask

  // cw: write in the same cycle as acceptance; bw: write attempted while busy
  task automatic resolve(input logic [5:0] c, input bit s, input string req,
                         input bit cw, input logic [3:0] csel, input logic [15:0] cdat,
                         input bit bw);
    logic [15:0] ev = 0, ea = 0, w;
    bit eh = 0, el = 0;
    int lat = 2;
    bit ext = (c >= 6'h10 && c <= 6'h17) || c == 6'h1E || c == 6'h1F;
    if (cw) mwrite(csel, cdat);
    if (s) begin
      if (ext) m_pc++;
    end else if (c < 6'h08) ev = m_gpr[c[2:0]];
    else if (c < 6'h10) begin ea = m_gpr[c[2:0]]; eh = 1; ev = memf(ea); lat = 3; end
    else if (c < 6'h18) begin
      w = memf(m_pc); m_pc++; m_cnt++; ea = w + m_gpr[c[2:0]]; eh = 1; ev = memf(ea); lat = 4;
    end else case (c)
      6'h18: begin ea = m_sp; m_sp++; eh = 1; ev = memf(ea); lat = 3; end
      6'h19: begin ea = m_sp; eh = 1; ev = memf(ea); lat = 3; end
      6'h1A: begin m_sp--; ea = m_sp; eh = 1; ev = memf(ea); lat = 3; end
      6'h1B: ev = m_sp;
      6'h1C: ev = m_pc;
      6'h1D: ev = m_ov;
      6'h1E: begin w = memf(m_pc); m_pc++; m_cnt++; ea = w; eh = 1; ev = memf(ea); lat = 4; end
      6'h1F: begin ev = memf(m_pc); m_pc++; m_cnt++; el = 1; lat = 3; end
      default: begin ev = {11'h0, c[4:0]}; el = 1; end
    endcase
    chk("R11", "ready before request", {31'h0, req_ready}, 32'h1);
    req_valid = 1; req_code = c; req_skip = s;
    if (cw) begin wr_en = 1; wr_sel = csel; wr_data = cdat; end
    @(posedge clk); @(negedge clk);
    req_valid = 0; wr_en = 0;
    for (int k = 1; k <= lat + 1; k++) begin
      if (bw && k == 1) begin wr_en = 1; wr_sel = 4'd0; wr_data = ~m_gpr[0]; end
      if (bw && k == 2) wr_en = 0;
      chk("R11", "done timing", {31'h0, done}, {31'h0, k == lat});
      if (k <= lat) chk("R11", "ready while busy", {31'h0, req_ready}, 32'h0);
      if (k == lat) begin
        chk(req, "value", {16'h0, res_value}, {16'h0, ev});
        chk(req, "has_addr", {31'h0, res_has_addr}, {31'h0, eh});
        if (eh) chk(req, "addr", {16'h0, res_addr}, {16'h0, ea});
        chk(s ? "R10" : "R8", "literal", {31'h0, res_literal}, {31'h0, el});
      end
      if (k <= lat) begin @(posedge clk); @(negedge clk); end
    end
    wr_en = 0;
    check_state(s ? "R10" : (bw ? "R12" : req));
  endtask

  function automatic string req_of(input logic [5:0] c);
    if (c < 6'h08) return "R1";
    if (c < 6'h10) return "R2";
    if (c < 6'h18) return "R3";
    if (c < 6'h1B) return "R4";
    if (c < 6'h1E) return "R5";
    if (c < 6'h20) return "R6";
    return "R7";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_gpr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R11", "ready after reset", {31'h0, req_ready}, 32'h1);
    chk("R11", "done after reset", {31'h0, done}, 32'h0);
    check_state("R12");
    // load registers through write port
    for (int i = 0; i < 8; i++) setreg(4'(i), 16'h1111 * 16'(i + 1) + 16'h0F);
    setreg(4'd8, 16'h0040);
    setreg(4'd9, 16'h1000);
    setreg(4'd10, 16'hBEEF);
    check_state("R12");
    // every code resolved
    for (int c = 0; c < 64; c++) resolve(6'(c), 1'b0, req_of(6'(c)), 1'b0, 4'd0, 16'h0, 1'b0);
    // every code in skip mode
    for (int c = 0; c < 64; c++) resolve(6'(c), 1'b1, "R10", 1'b0, 4'd0, 16'h0, 1'b0);
    // stack wrap: push at SP=0, pop at SP=FFFF
    setreg(4'd8, 16'h0000);
    resolve(6'h1A, 1'b0, "R4", 1'b0, 4'd0, 16'h0, 1'b0);
    resolve(6'h18, 1'b0, "R4", 1'b0, 4'd0, 16'h0, 1'b0);
    // indexed wrap and PC wrap
    setreg(4'd5, 16'hFFF8);
    setreg(4'd9, 16'hFFFF);
    resolve(6'h15, 1'b0, "R3", 1'b0, 4'd0, 16'h0, 1'b0);
    resolve(6'h1C, 1'b0, "R5", 1'b0, 4'd0, 16'h0, 1'b0);
    // write in same cycle as acceptance is seen by the request
    resolve(6'h03, 1'b0, "R12", 1'b1, 4'd3, 16'h5A17, 1'b0);
    resolve(6'h1D, 1'b0, "R12", 1'b1, 4'd10, 16'h0777, 1'b0);
    // write while busy is ignored
    resolve(6'h10, 1'b0, "R3", 1'b0, 4'd0, 16'h0, 1'b1);
    resolve(6'h00, 1'b0, "R12", 1'b0, 4'd0, 16'h0, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule